// File: doc/BRIEF.md
# I2C Register-File Target

This block lets an external I2C controller read and write an internal byte-wide register bank. SCL and SDA arrive from the pads and pass through two-flop synchronisers into the system clock domain. Edge detection in that domain finds START, repeated START and STOP conditions and the SCL edges. The block answers to one 7-bit device address. It acknowledges by asking the pad to pull SDA low, and it reaches the bank through a registered write port and a combinational read port.

Access goes through an 8-bit register pointer. In a write frame, the first byte after the address loads the pointer. Every byte after that is stored at the pointer, and the pointer then steps by one. A read frame streams bytes from the pointer onward. If the read address follows a plain START, the pointer first returns to 0x00. If it follows a repeated START, the pointer keeps the value set by the write that came before it. Locations above 0xC7 are reserved: writes there are acknowledged but discarded, and reads there return zero.

Top module: `i2c_reg_target`

## Requirements
- R1: After reset, sdaOe is 0 (SDA released) and regWe is 0.
- R2: A START followed by an address byte whose upper seven bits equal DEV_ADDR (default 0x2A, so 0x54 for a write) is acknowledged: SDA is low during the 9th SCL high phase.
- R3: In a write frame, the byte after the address loads the pointer and is acknowledged. Each later byte is acknowledged, produces one single-cycle regWe with regWaddr equal to the pointer, and then increments the pointer by one.
- R4: A write while the pointer is above 0xC7 is acknowledged but raises no regWe. A read while the pointer is above 0xC7 returns 0x00.
- R5: A read address (DEV_ADDR with R/W=1, default byte 0x55) after a plain START resets the pointer to 0x00, so register 0x00 is sent first.
- R6: A read address after a repeated START keeps the pointer loaded by the preceding write, so the preset register is sent first. The pointer increments after every byte sent.
- R7: A NACK from the controller after a read byte ends transmission, and SDA stays released until the next START or STOP.
- R8: SDA changes only while SCL is low, or at a START or STOP. Every read data bit is stable for the whole SCL high phase.
- R9: After a STOP, SDA is released, and a new read that starts with a plain START begins again at register 0x00.
- R10: An address byte that does not match is not acknowledged. Until the next START or STOP the block keeps SDA released and writes nothing.
- R11: The pointer wraps from 0xFF to 0x00 on increment, for both reads and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | SCL level from the pad |
| sdaIn | input | 1 | SDA level from the pad |
| sdaOe | output | 1 | 1 = pull SDA low, 0 = release |
| regWe | output | 1 | Register bank write strobe, one cycle |
| regWaddr | output | 8 | Register bank write address |
| regWdata | output | 8 | Register bank write data |
| regRaddr | output | 8 | Register bank read address (current pointer) |
| regRdata | input | 8 | Register bank read data, combinational from regRaddr |

## Verification
A wrong pointer becomes visible at the first data byte after it goes wrong. A stray write lands at an unexpected regWaddr, or a read returns the wrong register's value in the same byte on SDA. A wrong START/repeated-START flag changes which register leads a read, so the first byte returned after the address exposes it. A bit counter or state that is off by one shows within one byte time: the acknowledge slot moves and SDA is driven while SCL is high, or it is missing when the controller samples the 9th pulse.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_BYTE,
    ST_WR_ACK,
    ST_RD_BYTE,
    ST_RD_ACK,
    ST_IGNORE
  } tgtState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftIn;
    logic loadPtr;
    logic incPtr;
    logic clrPtr;
    logic writeReg;
    logic loadTx;
    logic shiftTx;
  } dpStrobe_t;
endpackage

// File: rtl/i2ct_bus_sync.sv
module i2ct_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclSync,
  output logic sdaSync,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);
  logic [STAGES-1:0] sclQ, sdaQ;
  logic sclPrev, sdaPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclQ    <= '1;
      sdaQ    <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclQ    <= {sclQ[STAGES-2:0], sclIn};
      sdaQ    <= {sdaQ[STAGES-2:0], sdaIn};
      sclPrev <= sclQ[STAGES-1];
      sdaPrev <= sdaQ[STAGES-1];
    end
  end

  assign sclSync  = sclQ[STAGES-1];
  assign sdaSync  = sdaQ[STAGES-1];
  assign sclRise  = sclSync & ~sclPrev;
  assign sclFall  = ~sclSync & sclPrev;
  assign startDet = sclSync & sclPrev & sdaPrev & ~sdaSync;
  assign stopDet  = sclSync & sclPrev & ~sdaPrev & sdaSync;
endmodule

// File: rtl/i2ct_ctrl.sv
module i2ct_ctrl
  import i2ct_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h2A
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sdaSync,
  input  logic              sclRise,
  input  logic              sclFall,
  input  logic              startDet,
  input  logic              stopDet,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              txMsb,
  output dpStrobe_t         stb,
  output logic              sdaOe,
  output logic              ignoring
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  tgtState_e        state, stateNxt;
  logic [CNT_W-1:0] bitCnt, cntNxt;
  logic busActive, busNxt;
  logic repStart, repNxt;
  logic rwBit, rwNxt;
  logic firstByte, firstNxt;
  logic masterAck, ackNxt;

  always_comb begin
    stb      = '0;
    stateNxt = state;
    cntNxt   = bitCnt;
    busNxt   = busActive;
    repNxt   = repStart;
    rwNxt    = rwBit;
    firstNxt = firstByte;
    ackNxt   = masterAck;
    if (stopDet) begin
      stateNxt = ST_IDLE;
      busNxt   = 1'b0;
    end else if (startDet) begin
      stateNxt = ST_ADDR;
      cntNxt   = '0;
      repNxt   = busActive;
      busNxt   = 1'b1;
    end else begin
      unique case (state)
        ST_ADDR: begin
          if (sclRise) begin
            stb.shiftIn = 1'b1;
            cntNxt      = bitCnt + 1'b1;
          end else if (sclFall && bitCnt == FULL) begin
            if (rxByte[BYTE_W-1:1] == DEV_ADDR) begin
              stateNxt   = ST_ADDR_ACK;
              rwNxt      = rxByte[0];
              stb.clrPtr = rxByte[0] & ~repStart;
            end else begin
              stateNxt = ST_IGNORE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (sclFall) begin
            cntNxt = '0;
            if (rwBit) begin
              stb.loadTx = 1'b1;
              stateNxt   = ST_RD_BYTE;
            end else begin
              firstNxt = 1'b1;
              stateNxt = ST_WR_BYTE;
            end
          end
        end
        ST_WR_BYTE: begin
          if (sclRise) begin
            stb.shiftIn = 1'b1;
            cntNxt      = bitCnt + 1'b1;
          end else if (sclFall && bitCnt == FULL) begin
            if (firstByte) begin
              stb.loadPtr = 1'b1;
            end else begin
              stb.writeReg = 1'b1;
              stb.incPtr   = 1'b1;
            end
            firstNxt = 1'b0;
            stateNxt = ST_WR_ACK;
          end
        end
        ST_WR_ACK: begin
          if (sclFall) begin
            cntNxt   = '0;
            stateNxt = ST_WR_BYTE;
          end
        end
        ST_RD_BYTE: begin
          if (sclRise) begin
            cntNxt = bitCnt + 1'b1;
          end else if (sclFall) begin
            if (bitCnt == FULL) begin
              stb.incPtr = 1'b1;
              stateNxt   = ST_RD_ACK;
            end else begin
              stb.shiftTx = 1'b1;
            end
          end
        end
        ST_RD_ACK: begin
          if (sclRise) begin
            ackNxt = ~sdaSync;
          end else if (sclFall) begin
            if (masterAck) begin
              stb.loadTx = 1'b1;
              cntNxt     = '0;
              stateNxt   = ST_RD_BYTE;
            end else begin
              stateNxt = ST_IGNORE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      busActive <= 1'b0;
      repStart  <= 1'b0;
      rwBit     <= 1'b0;
      firstByte <= 1'b0;
      masterAck <= 1'b0;
    end else begin
      state     <= stateNxt;
      bitCnt    <= cntNxt;
      busActive <= busNxt;
      repStart  <= repNxt;
      rwBit     <= rwNxt;
      firstByte <= firstNxt;
      masterAck <= ackNxt;
    end
  end

  assign sdaOe = (state == ST_ADDR_ACK) || (state == ST_WR_ACK) ||
                 ((state == ST_RD_BYTE) && !txMsb);
  assign ignoring = (state == ST_IGNORE);
endmodule

// File: rtl/i2ct_dpath.sv
module i2ct_dpath
  import i2ct_pkg::*;
#(
  parameter logic [BYTE_W-1:0] MAX_REG = 8'hC7
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic              sdaSync,
  input  logic [BYTE_W-1:0] regRdata,
  output logic [BYTE_W-1:0] rxByte,
  output logic              txMsb,
  output logic [BYTE_W-1:0] regRaddr,
  output logic              regWe,
  output logic [BYTE_W-1:0] regWaddr,
  output logic [BYTE_W-1:0] regWdata
);
  logic [BYTE_W-1:0] rxShift, txShift, ptr;
  logic ptrLegal;

  assign ptrLegal = (ptr <= MAX_REG);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift  <= '0;
      txShift  <= '1;
      ptr      <= '0;
      regWe    <= 1'b0;
      regWaddr <= '0;
      regWdata <= '0;
    end else begin
      regWe <= 1'b0;
      if (stb.shiftIn) rxShift <= {rxShift[BYTE_W-2:0], sdaSync};
      if (stb.loadTx)       txShift <= ptrLegal ? regRdata : '0;
      else if (stb.shiftTx) txShift <= {txShift[BYTE_W-2:0], 1'b1};
      if (stb.writeReg && ptrLegal) begin
        regWe    <= 1'b1;
        regWaddr <= ptr;
        regWdata <= rxShift;
      end
      if (stb.clrPtr)       ptr <= '0;
      else if (stb.loadPtr) ptr <= rxShift;
      else if (stb.incPtr)  ptr <= ptr + 1'b1;
    end
  end

  assign rxByte   = rxShift;
  assign txMsb    = txShift[BYTE_W-1];
  assign regRaddr = ptr;
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
  import i2ct_pkg::*;
#(
  parameter logic [6:0]        DEV_ADDR    = 7'h2A,
  parameter logic [BYTE_W-1:0] MAX_REG     = 8'hC7,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaOe,
  output logic              regWe,
  output logic [BYTE_W-1:0] regWaddr,
  output logic [BYTE_W-1:0] regWdata,
  output logic [BYTE_W-1:0] regRaddr,
  input  logic [BYTE_W-1:0] regRdata
);
  logic sclSync, sdaSync, sclRise, sclFall, startDet, stopDet;
  logic txMsb, ignoring;
  logic [BYTE_W-1:0] rxByte;
  dpStrobe_t stb;

  i2ct_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclSync(sclSync), .sdaSync(sdaSync), .sclRise(sclRise),
    .sclFall(sclFall), .startDet(startDet), .stopDet(stopDet)
  );

  i2ct_ctrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .sdaSync(sdaSync), .sclRise(sclRise),
    .sclFall(sclFall), .startDet(startDet), .stopDet(stopDet),
    .rxByte(rxByte), .txMsb(txMsb), .stb(stb), .sdaOe(sdaOe),
    .ignoring(ignoring)
  );

  i2ct_dpath #(.MAX_REG(MAX_REG)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .sdaSync(sdaSync),
    .regRdata(regRdata), .rxByte(rxByte), .txMsb(txMsb),
    .regRaddr(regRaddr), .regWe(regWe), .regWaddr(regWaddr),
    .regWdata(regWdata)
  );
endmodule

// File: rtl/i2ct_checker.sv
module i2ct_checker #(
  parameter logic [7:0] MAX_REG = 8'hC7
) (
  input logic       clk,
  input logic       rstN,
  input logic       sdaOe,
  input logic       sclSync,
  input logic       startDet,
  input logic       stopDet,
  input logic       ignoring,
  input logic       regWe,
  input logic [7:0] regWaddr
);
  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (sdaOe != $past(sdaOe)) |-> (!$past(sclSync) || $past(startDet) || $past(stopDet))); // R8

  AST_WE_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    regWe |-> (regWaddr <= MAX_REG)); // R4

  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    regWe |=> !regWe); // R3

  AST_IGNORE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    ignoring |-> !sdaOe); // R10

  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    $past(stopDet) |-> !sdaOe); // R9
endmodule

bind i2c_reg_target i2ct_checker #(.MAX_REG(MAX_REG)) u_chk (
  .clk(clk), .rstN(rstN), .sdaOe(sdaOe), .sclSync(sclSync),
  .startDet(startDet), .stopDet(stopDet), .ignoring(ignoring),
  .regWe(regWe), .regWaddr(regWaddr)
);

// File: tb/tb_i2c_reg_target.sv
`timescale 1ns/1ps
module tb_i2c_reg_target;
  localparam int Q = 10;
  localparam logic [7:0] WADDR = 8'h54;
  localparam logic [7:0] RADDR = 8'h55;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic sdaOe, regWe;
  logic [7:0] regWaddr, regWdata, regRaddr, regRdata;
  logic sdaBus;
  logic [7:0] bank [256];
  int checks = 0, fails = 0, weCount = 0, glitches = 0, quietViol = 0;
  logic quiet = 1'b0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  assign sdaBus   = sdaM & ~sdaOe;
  assign regRdata = bank[regRaddr];

  i2c_reg_target dut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus), .sdaOe(sdaOe),
    .regWe(regWe), .regWaddr(regWaddr), .regWdata(regWdata),
    .regRaddr(regRaddr), .regRdata(regRdata)
  );

  function automatic logic [7:0] initVal(input int i);
    return 8'(i) ^ 8'hA5;
  endfunction

  always @(posedge clk) begin
    if (regWe) begin
      bank[regWaddr] <= regWdata;
      weCount <= weCount + 1;
    end
  end

  always @(negedge clk) if (quiet && sdaOe) quietViol <= quietViol + 1;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic waitQ(input int n = Q);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart;
    sdaM = 1'b1; waitQ(); sclM = 1'b1; waitQ();
    sdaM = 1'b0; waitQ(); sclM = 1'b0; waitQ();
  endtask

  task automatic busStop;
    sdaM = 1'b0; waitQ(); sclM = 1'b1; waitQ(); sdaM = 1'b1; waitQ();
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; waitQ(); sclM = 1'b1; waitQ(); sclM = 1'b0; waitQ();
    end
    sdaM = 1'b1; waitQ(); sclM = 1'b1; waitQ(Q/2);
    ack = ~sdaBus;
    waitQ(Q - Q/2); sclM = 1'b0; waitQ();
  endtask

  task automatic recvByte(input logic giveAck, output logic [7:0] b);
    logic s1, s2;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      sdaM = 1'b1; waitQ(); sclM = 1'b1; waitQ(1);
      s1 = sdaBus; waitQ(Q - 1); s2 = sdaBus;
      if (s1 != s2) glitches++;
      b = {b[6:0], s2};
      sclM = 1'b0; waitQ();
    end
    sdaM = ~giveAck; waitQ(); sclM = 1'b1; waitQ(); sclM = 1'b0; waitQ();
  endtask

  task automatic testReset;
    chk("R1 sdaOe after reset", int'(sdaOe), 0);
    chk("R1 regWe after reset", int'(regWe), 0);
  endtask

  task automatic testPlainRead;
    logic a; logic [7:0] d;
    busStart(); sendByte(RADDR, a);
    chk("R2 read address ack", int'(a), 1);
    recvByte(1'b1, d); chk("R5 first byte reg 0x00", int'(d), int'(initVal(0)));
    recvByte(1'b0, d); chk("R5 second byte reg 0x01", int'(d), int'(initVal(1)));
    busStop();
    chk("R9 SDA released after STOP", int'(sdaOe), 0);
    busStart(); sendByte(RADDR, a);
    recvByte(1'b0, d); chk("R9 read after STOP restarts at 0x00", int'(d), int'(initVal(0)));
    busStop();
  endtask

  task automatic testWriteBurst;
    logic a; int w0;
    w0 = weCount;
    busStart(); sendByte(WADDR, a); chk("R2 write address ack", int'(a), 1);
    sendByte(8'h10, a); chk("R3 pointer byte ack", int'(a), 1);
    sendByte(8'hA1, a); chk("R3 data ack", int'(a), 1);
    sendByte(8'hB2, a); sendByte(8'hC3, a);
    busStop();
    chk("R3 reg 0x10", int'(bank[8'h10]), 'hA1);
    chk("R3 reg 0x11", int'(bank[8'h11]), 'hB2);
    chk("R3 reg 0x12", int'(bank[8'h12]), 'hC3);
    chk("R3 write strobe count", weCount - w0, 3);
    chk("R3 reg 0x13 untouched", int'(bank[8'h13]), int'(initVal('h13)));
  endtask

  task automatic testRepeatedRead;
    logic a; logic [7:0] d;
    busStart(); sendByte(WADDR, a); sendByte(8'h11, a);
    busStart(); sendByte(RADDR, a); chk("R6 read address ack", int'(a), 1);
    recvByte(1'b1, d); chk("R6 preset register first", int'(d), 'hB2);
    recvByte(1'b0, d); chk("R6 pointer advanced", int'(d), 'hC3);
    busStop();
  endtask

  task automatic testNack;
    logic a; logic [7:0] d;
    busStart(); sendByte(RADDR, a);
    recvByte(1'b0, d);
    quiet = 1'b1;
    recvByte(1'b0, d);
    quiet = 1'b0;
    chk("R7 bus released after NACK", int'(d), 'hFF);
    busStop();
  endtask

  task automatic testReserved;
    logic a; logic [7:0] d; int w0;
    w0 = weCount;
    busStart(); sendByte(WADDR, a); sendByte(8'hC7, a);
    sendByte(8'h11, a); sendByte(8'h22, a);
    chk("R4 reserved write still acked", int'(a), 1);
    busStop();
    chk("R4 reg 0xC7 written", int'(bank[8'hC7]), 'h11);
    chk("R4 one strobe only", weCount - w0, 1);
    busStart(); sendByte(WADDR, a); sendByte(8'hC8, a);
    busStart(); sendByte(RADDR, a);
    recvByte(1'b0, d); chk("R4 reserved read is zero", int'(d), 0);
    busStop();
  endtask

  task automatic testWrap;
    logic a; logic [7:0] d; int w0;
    busStart(); sendByte(WADDR, a); sendByte(8'hFF, a);
    busStart(); sendByte(RADDR, a);
    recvByte(1'b1, d); chk("R11 read 0xFF reserved", int'(d), 0);
    recvByte(1'b0, d); chk("R11 read wraps to 0x00", int'(d), int'(initVal(0)));
    busStop();
    w0 = weCount;
    busStart(); sendByte(WADDR, a); sendByte(8'hFF, a);
    sendByte(8'h33, a); sendByte(8'h44, a);
    busStop();
    chk("R11 write wraps to 0x00", int'(bank[0]), 'h44);
    chk("R11 strobe count", weCount - w0, 1);
  endtask

  task automatic testMismatch;
    logic a; logic [7:0] d; int w0;
    w0 = weCount;
    busStart();
    quiet = 1'b1;
    sendByte(8'h26, a); chk("R10 mismatch not acked", int'(a), 0);
    sendByte(8'h20, a); sendByte(8'h77, a);
    quiet = 1'b0;
    busStop();
    chk("R10 no writes", weCount - w0, 0);
    chk("R10 SDA never driven", quietViol, 0);
    busStart(); sendByte(RADDR, a); chk("R10 next START matches again", int'(a), 1);
    recvByte(1'b0, d); busStop();
  endtask

  initial begin
    for (int i = 0; i < 256; i++) bank[i] = initVal(i);
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    testReset();
    testPlainRead();
    testWriteBurst();
    testRepeatedRead();
    testNack();
    testReserved();
    testWrap();
    testMismatch();
    chk("R8 read bits stable while SCL high", glitches, 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=complete");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule